// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block sits on the controller side of a single DRAM bank and turns read requests into a legal command stream. Each request carries a row and a column. The block remembers which row is open. It issues an ACTIVATE when the bank is closed. It issues a PRECHARGE followed by an ACTIVATE when a different row is wanted. It then issues the READ and raises a data-valid strobe once the column latency has elapsed.

Four cycle counts are programmable: column latency, activate-to-read delay, precharge-to-activate delay and activate-to-precharge minimum. A 1T/2T command-rate option adds a chip-select lead cycle before every command. The timing inputs are captured when a request is accepted. Each command goes out in the first cycle that every constraint allows. Between commands the bus carries NOP.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset `req_ready` is 1, `busy` is 0, `cmd_cs` is 0, `cmd_code` is NOP and `rd_valid` is 0.
- R2: `req_ready` is high only while the sequencer is idle. It stays low from the cycle after acceptance through the cycle of the data strobe, and it is high again in the next cycle. `busy` is always the inverse of `req_ready`.
- R3: With no row open, an accepted request produces ACTIVATE and then READ. In 1T mode, when no earlier timing limit is pending, the ACTIVATE appears in the cycle right after acceptance.
- R4: A READ is never issued fewer than the activate-to-read count of cycles after the last ACTIVATE.
- R5: `rd_valid` is high for exactly one cycle, exactly column-latency cycles after the READ.
- R6: An ACTIVATE is never issued fewer than the precharge-to-activate count of cycles after the last PRECHARGE.
- R7: A PRECHARGE is never issued fewer than the activate-to-precharge count of cycles after the last ACTIVATE.
- R8: A request to the open row produces only a READ. A request to a different row produces PRECHARGE, ACTIVATE with the new row on `cmd_row`, then READ. An ACTIVATE is never issued while a row is open.
- R9: In 1T mode every command is issued in the first cycle in which all of its delay limits are met.
- R10: In 2T mode every command is preceded by exactly one cycle with `cmd_cs`=1 and `cmd_code`=NOP, so each command comes one cycle later than in 1T. In 1T mode `cmd_cs` is never high together with NOP.
- R11: `cmd_code` encodes NOP=2'b00, ACTIVATE=2'b01, READ=2'b10, PRECHARGE=2'b11. At most one command is issued per cycle, and whenever `cmd_cs` is 0 the code is NOP. `cmd_col` carries the request column during READ.
- R12: A timing input of 0 behaves as 1.
- R13: Timing and command-rate inputs are captured at request acceptance. Changing them while busy has no effect on the request in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_row | input | ROW_W | Requested row |
| req_col | input | COL_W | Requested column |
| cfg_cl | input | TW | Column latency, cycles |
| cfg_trcd | input | TW | Activate-to-read delay, cycles |
| cfg_trp | input | TW | Precharge-to-activate delay, cycles |
| cfg_tras | input | TW | Activate-to-precharge minimum, cycles |
| cfg_two_t | input | 1 | 1 selects 2T command rate |
| busy | output | 1 | Command sequence or data return in progress |
| cmd_cs | output | 1 | Chip select |
| cmd_code | output | 2 | Command code |
| cmd_row | output | ROW_W | Row address, valid on ACTIVATE |
| cmd_col | output | COL_W | Column address, valid on READ |
| rd_valid | output | 1 | Read data valid strobe |

## Verification
A corrupt open-row record shows up at once as a wrong command mix. A hit that emits ACTIVATE, or a miss that skips PRECHARGE, appears in the first command cycle after acceptance. A wrong elapsed-time count shows up as a command placed too early, or as one placed later than the exact 1T schedule. A wrongly captured timing value shows up as a data strobe that does not land at READ plus the latency sampled at acceptance. The bench models the bank and the expected schedule from the requirements, and it checks every command cycle against them.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
   typedef enum logic [1:0] {
      CMD_NOP = 2'b00,
      CMD_ACT = 2'b01,
      CMD_RD  = 2'b10,
      CMD_PRE = 2'b11
   } dcmd_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_PRE  = 3'd1,
      ST_ACT  = 3'd2,
      ST_RD   = 3'd3,
      ST_DATA = 3'd4
   } dstate_e;

   localparam int unsigned NUM_TIMING = 4;
   localparam int unsigned IDX_CL  = 0;
   localparam int unsigned IDX_RCD = 1;
   localparam int unsigned IDX_RP  = 2;
   localparam int unsigned IDX_RAS = 3;

   localparam int unsigned NUM_EVT = 3;
   localparam int unsigned EV_ACT  = 0;
   localparam int unsigned EV_PRE  = 1;
   localparam int unsigned EV_RD   = 2;
endpackage

// File: rtl/dseq_elapsed.sv
module dseq_elapsed #(
   parameter int unsigned CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mark,
   output logic [CW-1:0] count
);
   localparam logic [CW-1:0] SAT = '1;
   localparam logic [CW-1:0] ONE = CW'(1);

   if (CW < 2) begin : g_bad_cw
      $error("dseq_elapsed: CW must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)            count <= SAT;
      else if (mark)         count <= ONE;
      else if (count != SAT) count <= count + ONE;
   end

   // R9: the count restarts at one in the cycle after the event
   a_r9_restart_after_mark: assert property (@(posedge clk) disable iff (!rst_n)
      mark |=> count == ONE);
endmodule

// File: rtl/dseq_timing_latch.sv
module dseq_timing_latch #(
   parameter int unsigned TW = 4,
   parameter int unsigned NT = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [NT-1:0][TW-1:0] raw,
   input  logic                 two_t_in,
   output logic [NT-1:0][TW-1:0] eff,
   output logic                 two_t
);
   localparam logic [TW-1:0] ONE = TW'(1);

   if (TW < 2 || TW > 8) begin : g_bad_tw
      $error("dseq_timing_latch: TW out of range 2..8");
   end

   for (genvar g = 0; g < NT; g++) begin : g_field
      always_ff @(posedge clk) begin
         if (!rst_n)    eff[g] <= ONE;
         else if (load) eff[g] <= (raw[g] == '0) ? ONE : raw[g];
      end
      // R12: a captured value is never zero
      a_r12_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
         eff[g] != '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    two_t <= 1'b0;
      else if (load) two_t <= two_t_in;
   end

   // R13: captured values move only on a load
   a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(eff) && $stable(two_t));
endmodule

// File: rtl/dseq_row_track.sv
module dseq_row_track #(
   parameter int unsigned ROW_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_fire,
   input  logic             pre_fire,
   input  logic [ROW_W-1:0] act_row,
   input  logic [ROW_W-1:0] probe_row,
   output logic             row_open,
   output logic             row_hit
);
   logic [ROW_W-1:0] open_row;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_open <= 1'b0;
         open_row <= '0;
      end else if (act_fire) begin
         row_open <= 1'b1;
         open_row <= act_row;
      end else if (pre_fire) begin
         row_open <= 1'b0;
      end
   end

   assign row_hit = row_open && (open_row == probe_row);

   // R8: no activate into an open bank, no precharge of a closed one
   a_r8_act_closed: assert property (@(posedge clk) disable iff (!rst_n)
      act_fire |-> !row_open);
   a_r8_pre_open: assert property (@(posedge clk) disable iff (!rst_n)
      pre_fire |-> row_open);
endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
   import dseq_pkg::*;
#(
   parameter int unsigned ROW_W = 14,
   parameter int unsigned COL_W = 10,
   parameter int unsigned TW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [ROW_W-1:0] req_row,
   input  logic [COL_W-1:0] req_col,
   input  logic [TW-1:0]    cfg_cl,
   input  logic [TW-1:0]    cfg_trcd,
   input  logic [TW-1:0]    cfg_trp,
   input  logic [TW-1:0]    cfg_tras,
   input  logic             cfg_two_t,
   output logic             busy,
   output logic             cmd_cs,
   output logic [1:0]       cmd_code,
   output logic [ROW_W-1:0] cmd_row,
   output logic [COL_W-1:0] cmd_col,
   output logic             rd_valid
);
   localparam int unsigned CW = TW + 1;

   if (ROW_W < 1 || COL_W < 1) begin : g_bad_addr
      $error("dram_bank_seq: address widths must be positive");
   end

   dstate_e                      state, state_nx;
   logic                         sel_done;
   logic [ROW_W-1:0]             lat_row;
   logic [COL_W-1:0]             lat_col;
   logic [NUM_TIMING-1:0][TW-1:0] cfg_raw, cfg_eff;
   logic                         two_t;
   logic                         accept, elig, fire, sel_fire;
   logic                         row_open, row_hit;
   logic [NUM_EVT-1:0]           ev_mark;
   logic [NUM_EVT-1:0][CW-1:0]   ev_cnt;
   dcmd_e                        st_cmd;

   assign cfg_raw = {cfg_tras, cfg_trp, cfg_trcd, cfg_cl};
   assign accept  = req_valid && req_ready;

   dseq_timing_latch #(.TW(TW), .NT(NUM_TIMING)) u_tlat (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .raw      (cfg_raw),
      .two_t_in (cfg_two_t),
      .eff      (cfg_eff),
      .two_t    (two_t)
   );

   for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
      dseq_elapsed #(.CW(CW)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .mark  (ev_mark[e]),
         .count (ev_cnt[e])
      );
   end

   dseq_row_track #(.ROW_W(ROW_W)) u_rows (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_fire  (ev_mark[EV_ACT]),
      .pre_fire  (ev_mark[EV_PRE]),
      .act_row   (lat_row),
      .probe_row (req_row),
      .row_open  (row_open),
      .row_hit   (row_hit)
   );

   // eligibility of the command owned by the current state
   always_comb begin
      elig   = 1'b0;
      st_cmd = CMD_NOP;
      unique case (state)
         ST_PRE: begin
            st_cmd = CMD_PRE;
            elig   = ev_cnt[EV_ACT] >= {1'b0, cfg_eff[IDX_RAS]};
         end
         ST_ACT: begin
            st_cmd = CMD_ACT;
            elig   = ev_cnt[EV_PRE] >= {1'b0, cfg_eff[IDX_RP]};
         end
         ST_RD: begin
            st_cmd = CMD_RD;
            elig   = ev_cnt[EV_ACT] >= {1'b0, cfg_eff[IDX_RCD]};
         end
         default: ;
      endcase
   end

   assign fire     = elig && (!two_t || sel_done);
   assign sel_fire = elig && two_t && !sel_done;

   assign ev_mark[EV_ACT] = fire && (state == ST_ACT);
   assign ev_mark[EV_PRE] = fire && (state == ST_PRE);
   assign ev_mark[EV_RD]  = fire && (state == ST_RD);

   assign rd_valid = (state == ST_DATA) && (ev_cnt[EV_RD] == {1'b0, cfg_eff[IDX_CL]});

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE: if (accept) state_nx = !row_open ? ST_ACT : (row_hit ? ST_RD : ST_PRE);
         ST_PRE:  if (fire)   state_nx = ST_ACT;
         ST_ACT:  if (fire)   state_nx = ST_RD;
         ST_RD:   if (fire)   state_nx = ST_DATA;
         ST_DATA: if (rd_valid) state_nx = ST_IDLE;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         sel_done <= 1'b0;
         lat_row  <= '0;
         lat_col  <= '0;
      end else begin
         state <= state_nx;
         if (accept) begin
            lat_row <= req_row;
            lat_col <= req_col;
         end
         if (accept || fire) sel_done <= 1'b0;
         else if (sel_fire)  sel_done <= 1'b1;
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign busy      = !req_ready;
   assign cmd_cs    = fire || sel_fire;
   assign cmd_code  = fire ? st_cmd : CMD_NOP;
   assign cmd_row   = (fire && state == ST_ACT) ? lat_row : '0;
   assign cmd_col   = (fire && state == ST_RD)  ? lat_col : '0;

   // R11: deselected cycles carry NOP
   a_r11_nop_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_cs |-> cmd_code == CMD_NOP);
   // R4: read respects activate-to-read delay
   a_r4_trcd: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_code == CMD_RD |-> ev_cnt[EV_ACT] >= {1'b0, cfg_eff[IDX_RCD]});
   // R6: activate respects precharge time
   a_r6_trp: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_code == CMD_ACT |-> ev_cnt[EV_PRE] >= {1'b0, cfg_eff[IDX_RP]});
   // R7: precharge respects row active minimum
   a_r7_tras: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_code == CMD_PRE |-> ev_cnt[EV_ACT] >= {1'b0, cfg_eff[IDX_RAS]});
   // R2: idle again right after the data strobe
   a_r2_ready_after_data: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> req_ready);
   // R5: the strobe is a single cycle
   a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);
   // R10: in 2T a select cycle precedes every command
   a_r10_select_lead: assert property (@(posedge clk) disable iff (!rst_n)
      (two_t && cmd_code != CMD_NOP) |-> ($past(cmd_cs) && $past(cmd_code) == CMD_NOP));
endmodule

// File: tb/dram_bank_seq_bench.sv
`timescale 1ns/1ps
module dram_bank_seq_bench;
   localparam int ROW_W = 14;
   localparam int COL_W = 10;
   localparam int TW    = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [ROW_W-1:0] req_row = '0;
   logic [COL_W-1:0] req_col = '0;
   logic [TW-1:0]    cfg_cl = 1, cfg_trcd = 1, cfg_trp = 1, cfg_tras = 1;
   logic             cfg_two_t = 1'b0;
   logic             busy, cmd_cs, rd_valid;
   logic [1:0]       cmd_code;
   logic [ROW_W-1:0] cmd_row;
   logic [COL_W-1:0] cmd_col;

   always #2 clk = ~clk;

   dram_bank_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .TW(TW)) u_dram_bank_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_row(req_row), .req_col(req_col), .cfg_cl(cfg_cl), .cfg_trcd(cfg_trcd),
      .cfg_trp(cfg_trp), .cfg_tras(cfg_tras), .cfg_two_t(cfg_two_t), .busy(busy),
      .cmd_cs(cmd_cs), .cmd_code(cmd_code), .cmd_row(cmd_row), .cmd_col(cmd_col),
      .rd_valid(rd_valid)
   );

   int checks = 0, errors = 0, cyc = 0, done_cnt = 0;
   bit mon_en = 0, pending = 0, finished = 0;
   int t_acc = -100, t_pre = -1, t_act = -1, t_rd = -1, t_val = -100;
   int last_act = -1000, last_pre = -1000;
   int l_cl = 1, l_rcd = 1, l_rp = 1, l_ras = 1;
   bit l_two = 0;
   bit m_open = 0;
   int m_row = 0, q_row = 0, q_col = 0;
   int exp_seq [3];
   int exp_len = 0, seq_idx = 0;
   bit prev_cs = 0;
   int prev_code = 0;

   function automatic int eff(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   always @(posedge clk) cyc++;

   // responder and scoreboard
   always @(negedge clk) begin
      if (mon_en) begin
         if (req_valid && req_ready) begin
            pending = 1; t_acc = cyc; t_pre = -1; t_act = -1; t_rd = -1;
            l_cl = eff(cfg_cl); l_rcd = eff(cfg_trcd); l_rp = eff(cfg_trp); l_ras = eff(cfg_tras);
            l_two = cfg_two_t; q_row = req_row; q_col = req_col; seq_idx = 0;
            if (!m_open) begin exp_seq[0] = 1; exp_seq[1] = 2; exp_len = 2; end
            else if (m_row == q_row) begin exp_seq[0] = 2; exp_len = 1; end
            else begin exp_seq[0] = 3; exp_seq[1] = 1; exp_seq[2] = 2; exp_len = 3; end
         end
         chk(busy == !req_ready, "R2 busy inverse", busy, !req_ready);
         if (pending && cyc > t_acc) chk(!req_ready, "R2 ready low while busy", req_ready, 0);
         if (cyc == t_val + 1) chk(req_ready, "R2 ready after strobe", req_ready, 1);
         if (!cmd_cs) chk(cmd_code == 0, "R11 NOP when deselected", cmd_code, 0);
         if (cmd_cs && cmd_code == 0 && !l_two) chk(0, "R10 select cycle in 1T", 1, 0);
         if (cmd_code != 0) begin
            chk(pending && seq_idx < exp_len && int'(cmd_code) == exp_seq[seq_idx % 3],
                "R8 command order", cmd_code, exp_seq[seq_idx % 3]);
            if (l_two) chk(prev_cs && prev_code == 0, "R10 select lead", prev_cs, 1);
            case (cmd_code)
               2'b01: begin
                  chk(cyc - last_pre >= l_rp, "R6 precharge-to-activate", cyc - last_pre, l_rp);
                  chk(!m_open, "R8 activate into open bank", m_open, 0);
                  chk(int'(cmd_row) == q_row, "R8 activate row", cmd_row, q_row);
                  last_act = cyc; t_act = cyc; m_open = 1; m_row = cmd_row;
               end
               2'b10: begin
                  chk(cyc - last_act >= l_rcd, "R4 activate-to-read", cyc - last_act, l_rcd);
                  chk(int'(cmd_col) == q_col, "R11 read column", cmd_col, q_col);
                  t_rd = cyc;
               end
               default: begin
                  chk(cyc - last_act >= l_ras, "R7 activate-to-precharge", cyc - last_act, l_ras);
                  last_pre = cyc; t_pre = cyc; m_open = 0;
               end
            endcase
            seq_idx++;
         end
         if (rd_valid) begin
            chk(pending && t_rd >= 0 && cyc == t_rd + l_cl, "R5 strobe latency", cyc - t_rd, l_cl);
            chk(seq_idx == exp_len, "R8 command count", seq_idx, exp_len);
            t_val = cyc; pending = 0; done_cnt++;
         end
         prev_cs = cmd_cs; prev_code = cmd_code;
      end
   end

   task automatic send(input int row, input int col, input int cl, input int rcd,
                       input int rp, input int ras, input bit two);
      do begin @(posedge clk); #1; end while (!req_ready);
      req_row = row[ROW_W-1:0]; req_col = col[COL_W-1:0];
      cfg_cl = cl[TW-1:0]; cfg_trcd = rcd[TW-1:0]; cfg_trp = rp[TW-1:0]; cfg_tras = ras[TW-1:0];
      cfg_two_t = two; req_valid = 1'b1;
      @(posedge clk); #1;
      req_valid = 1'b0;
      // R13: disturb the timing inputs while the request is in flight
      cfg_cl = TW'($urandom); cfg_trcd = TW'($urandom); cfg_trp = TW'($urandom);
      cfg_tras = TW'($urandom); cfg_two_t = ~two;
   endtask

   task automatic send_wait(input int row, input int col, input int cl, input int rcd,
                            input int rp, input int ras, input bit two);
      int n = done_cnt;
      send(row, col, cl, rcd, rp, ras, two);
      while (done_cnt == n) @(posedge clk);
   endtask

   task automatic summary;
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired, run did not complete");
      summary();
   end

   initial begin
      int a1;
      void'($urandom(32'd7741));
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
      chk(busy == 0, "R1 busy after reset", busy, 0);
      chk(cmd_cs == 0 && cmd_code == 0, "R1 bus idle after reset", cmd_cs, 0);
      chk(rd_valid == 0, "R1 strobe after reset", rd_valid, 0);
      mon_en = 1;

      // R3 cold bank, 1T, 2-3-2-5
      send_wait(5, 17, 2, 3, 2, 5, 0);
      chk(t_act == t_acc + 1, "R3 activate after accept", t_act - t_acc, 1);
      chk(t_rd == t_acc + 4, "R9 read at tRCD", t_rd - t_acc, 4);
      chk(t_val == t_acc + 6, "R5 strobe at CL", t_val - t_acc, 6);

      // R8 row hit: only a read
      repeat (10) @(posedge clk);
      send_wait(5, 99, 2, 3, 2, 5, 0);
      chk(t_act == -1 && t_pre == -1, "R8 hit issues no activate", t_act, -1);
      chk(t_rd == t_acc + 1, "R8 hit read next cycle", t_rd - t_acc, 1);

      // R9 row miss after idle
      repeat (20) @(posedge clk);
      send_wait(9, 3, 2, 3, 2, 5, 0);
      chk(t_pre == t_acc + 1, "R9 precharge first", t_pre - t_acc, 1);
      chk(t_act == t_pre + 2, "R9 activate at tRP", t_act - t_pre, 2);
      chk(t_rd == t_act + 3, "R9 read at tRCD", t_rd - t_act, 3);

      // R7 long tRAS holds the next precharge
      repeat (20) @(posedge clk);
      send_wait(11, 1, 1, 1, 1, 15, 0);
      a1 = t_act;
      send_wait(12, 2, 1, 1, 1, 15, 0);
      chk(t_pre == a1 + 15, "R7 precharge exactly at tRAS", t_pre - a1, 15);

      // R12 zero timing values act as one
      repeat (20) @(posedge clk);
      send_wait(13, 4, 0, 0, 0, 0, 0);
      chk(t_pre == t_acc + 1 && t_act == t_acc + 2, "R12 zero delays pre/act", t_act - t_acc, 2);
      chk(t_rd == t_acc + 3 && t_val == t_acc + 4, "R12 zero delays read/strobe", t_val - t_acc, 4);

      // R10 2T command rate on a miss
      repeat (20) @(posedge clk);
      send_wait(14, 6, 2, 2, 3, 1, 1);
      chk(t_pre == t_acc + 2, "R10 2T precharge", t_pre - t_acc, 2);
      chk(t_act == t_pre + 4, "R10 2T activate", t_act - t_pre, 4);
      chk(t_rd == t_act + 3, "R10 2T read", t_rd - t_act, 3);
      chk(t_val == t_rd + 2, "R10 2T strobe", t_val - t_rd, 2);

      // R13 latency captured at accept despite later input changes
      repeat (10) @(posedge clk);
      send_wait(14, 8, 3, 1, 1, 1, 0);
      chk(t_val == t_rd + 3, "R13 latency held after accept", t_val - t_rd, 3);

      // random traffic over a few rows
      for (int i = 0; i < 300; i++) begin
         int gap = $urandom_range(0, 3);
         repeat (gap) @(posedge clk);
         send($urandom_range(0, 3), $urandom_range(0, 1023), $urandom_range(0, 6),
              $urandom_range(0, 6), $urandom_range(0, 6),
              ($urandom_range(0, 7) == 0) ? 15 : $urandom_range(0, 8), 1'($urandom_range(0, 1)));
      end
      repeat (80) @(posedge clk);
      chk(!pending, "R2 all requests returned", pending, 0);
      summary();
   end
endmodule